// File: doc/BRIEF.md
# Programmable Clock Output Divider

This block derives an output clock from a fixed reference by dividing it by N+1, where N is a 4-bit factor. N is loaded together with two suspend-policy bits by a single load strobe. The output frequency is the reference rate divided by N+1, and odd divisors are supported. With a 48 MHz reference, the reset factor of 11 gives 4 MHz, which is also the lowest rate the block will produce.

A suspend input, combined with the two policy bits, chooses one of three output sources:

- the divided clock,
- an externally supplied slow clock,
- a constant low (stopped).

The block also drives a slow-clock indicator and a request to turn the PLL off. The slow clock is resampled in the reference domain. All source changes happen only while the outgoing and incoming levels are both low, so no shortened pulse reaches the output. A new division factor waits for the end of the current output period before it takes effect.

Top module: `clk_out_divider`

## Requirements
- R1: For an active factor N from 1 to 11, `clk_out` repeats every N+1 reference cycles. It is high for floor((N+1)/2) cycles and low for the remaining cycles, so for odd divisors the high phase is one cycle shorter than the low phase.
- R2: With N = 0, `clk_out` runs at the reference rate: it is high while the reference is high and low while it is low.
- R3: A loaded factor above 11 acts exactly as 11 (period of 12 reference cycles).
- R4: After reset the factor is 11, both policy bits are 0, `slow_sel` and `pll_off_req` are 0, and the output period is 12 cycles with a 6/6 duty.
- R5: A factor loaded during an output period does not shorten or stretch that period. The next full period uses the new factor.
- R6: With `cfg_noslow`=0 and `cfg_run`=0, suspend moves the output to the slow clock, raises `slow_sel`, and raises `pll_off_req`.
- R7: With `cfg_noslow`=1 and `cfg_run`=0, suspend holds `clk_out` low. `slow_sel` stays 0 and `pll_off_req` is 1.
- R8: With `cfg_noslow`=0 and `cfg_run`=1, suspend moves the output to the slow clock with `slow_sel`=1 and `pll_off_req`=0.
- R9: With both policy bits set to 1, suspend changes nothing: the divided clock continues with its period, `slow_sel`=0 and `pll_off_req`=0.
- R10: When suspend is released, the output returns to the divided clock with its programmed period, and `slow_sel` and `pll_off_req` return to 0.
- R11: The output source changes only after a cycle in which `clk_out` was low, so no runt pulse appears at a source change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock (nominally 48 MHz) |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Strobe that loads the factor and policy bits |
| cfg_div | input | 4 | Division factor N (output = reference / (N+1)) |
| cfg_noslow | input | 1 | Policy bit: do not use the slow clock in suspend |
| cfg_run | input | 1 | Policy bit: keep the PLL running in suspend |
| suspend_in | input | 1 | Suspend state, synchronous to clk_ref |
| clk_slow | input | 1 | Slow clock used during suspend |
| clk_out | output | 1 | Output clock |
| slow_sel | output | 1 | High while the output is taken from the slow clock |
| pll_off_req | output | 1 | Request to switch the PLL off |

## Verification
The bench measures high and low run lengths for random factors, including odd divisors, where a swapped duty split would show up as an extra cycle of high time. Values above 11 are also measured; an unclamped design would give a longer period. A factor is loaded just after a rising edge, and the bench checks that the period in progress keeps its old length: a design that restarted the counter at once would produce a short period. Each suspend policy is exercised, and every slow-select change is checked to follow a low output sample, which exposes a switch that cuts a high pulse short. The reference-rate pass-through at N = 0 is probed in both clock phases.

// File: rtl/clk_out_divider.sv
module clk_out_divider #(
  parameter int DIV_W     = 4,
  parameter int DIV_MAX   = 11,
  parameter int DIV_RESET = 11
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_noslow,
  input  logic             cfg_run,
  input  logic             suspend_in,
  input  logic             clk_slow,
  output logic             clk_out,
  output logic             slow_sel,
  output logic             pll_off_req
);

  localparam logic [DIV_W-1:0] N_MAX = DIV_W'(DIV_MAX);
  localparam logic [DIV_W-1:0] N_RST = DIV_W'(DIV_RESET);
  localparam logic [1:0] SRC_DIV  = 2'd0;
  localparam logic [1:0] SRC_SLOW = 2'd1;
  localparam logic [1:0] SRC_STOP = 2'd2;

  logic [DIV_W-1:0] act_n, pend_n, cnt, nxt_cnt, nxt_n, load_n;
  logic [DIV_W:0]   nxt_d;
  logic             noslow_q, run_q, div_q, s1, s2;
  logic [1:0]       src, tgt;
  logic             wrap, cur_lvl, tgt_lvl;

  assign load_n  = (cfg_div > N_MAX) ? N_MAX : cfg_div;
  assign wrap    = (cnt == act_n);
  assign nxt_cnt = wrap ? '0 : cnt + 1'b1;
  assign nxt_n   = wrap ? pend_n : act_n;
  assign nxt_d   = {1'b0, nxt_n} + 1'b1;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      pend_n   <= N_RST;
      act_n    <= N_RST;
      cnt      <= '0;
      div_q    <= 1'b0;
      noslow_q <= 1'b0;
      run_q    <= 1'b0;
    end else begin
      if (cfg_load) begin
        pend_n   <= load_n;
        noslow_q <= cfg_noslow;
        run_q    <= cfg_run;
      end
      cnt   <= nxt_cnt;
      act_n <= nxt_n;
      div_q <= ({1'b0, nxt_cnt} < (nxt_d >> 1));
    end
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= clk_slow;
      s2 <= s1;
    end
  end

  always_comb begin
    if (!suspend_in || (noslow_q && run_q)) tgt = SRC_DIV;
    else if (noslow_q)                      tgt = SRC_STOP;
    else                                    tgt = SRC_SLOW;
  end

  function automatic logic lvl_of(input logic [1:0] s, input logic d, input logic w);
    return (s == SRC_DIV) ? d : (s == SRC_SLOW) ? w : 1'b0;
  endfunction

  assign cur_lvl = lvl_of(src, div_q, s2);
  assign tgt_lvl = lvl_of(tgt, div_q, s2);

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) src <= SRC_DIV;
    else if (src != tgt && !cur_lvl && !tgt_lvl) src <= tgt;
  end

  assign clk_out     = (src == SRC_DIV)  ? ((act_n == '0) ? clk_ref : div_q) :
                       (src == SRC_SLOW) ? s2 : 1'b0;
  assign slow_sel    = (src == SRC_SLOW);
  assign pll_off_req = (src != SRC_DIV) && !run_q;

  p_clamp_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    act_n <= N_MAX && pend_n <= N_MAX);

  p_period_end_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    act_n != $past(act_n) |-> $past(cnt) == $past(act_n));

  p_glitch_free_r11: assert property (@(posedge clk_ref) disable iff (!rst_n)
    src != $past(src) |-> !$past(cur_lvl));

  p_pll_kept_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
    run_q |-> !pll_off_req);

  p_stop_low_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    src == SRC_STOP |-> !clk_out);

endmodule

// File: tb/clk_out_divider_test.sv
module clk_out_divider_test;
  logic clk = 1'b0, rst_n = 1'b0, cfg_load = 1'b0, cfg_noslow = 1'b0, cfg_run = 1'b0;
  logic suspend_in = 1'b0, clk_slow = 1'b0;
  logic [3:0] cfg_div = 4'd0;
  logic clk_out, slow_sel, pll_off_req;
  int n_chk = 0, n_bad = 0;

  clk_out_divider uut (
    .clk_ref(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_div(cfg_div),
    .cfg_noslow(cfg_noslow), .cfg_run(cfg_run), .suspend_in(suspend_in),
    .clk_slow(clk_slow), .clk_out(clk_out), .slow_sel(slow_sel),
    .pll_off_req(pll_off_req));

  always #5 clk = ~clk;
  always #73 clk_slow = ~clk_slow;

  function automatic int exp_d(input int n);
    return ((n > 11) ? 11 : n) + 1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load(input int n, input bit ns, input bit rn);
    @(negedge clk);
    cfg_div = 4'(n); cfg_noslow = ns; cfg_run = rn; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic wait_rise();
    logic prev;
    @(negedge clk); prev = clk_out;
    @(negedge clk);
    while (!(!prev && clk_out)) begin prev = clk_out; @(negedge clk); end
  endtask

  task automatic measure(output int h, output int l);
    wait_rise();
    h = 0; l = 0;
    while (clk_out)  begin h++; @(negedge clk); end
    while (!clk_out) begin l++; @(negedge clk); end
  endtask

  task automatic check_period(input int n, input string req);
    int h, l, d;
    d = exp_d(n);
    measure(h, l);
    check(h == d / 2, req, h, d / 2);
    check(l == d - d / 2, req, l, d - d / 2);
  endtask

  task automatic wait_watch(input int cycles);
    logic ps, po;
    @(negedge clk); ps = slow_sel; po = clk_out;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (slow_sel != ps) check(po == 1'b0, "R11", int'(po), 0);
      ps = slow_sel; po = clk_out;
    end
  endtask

  task automatic count_edges(input int cycles, output int edges, output int highs);
    logic p;
    edges = 0; highs = 0;
    @(negedge clk); p = clk_out;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (clk_out != p) edges++;
      if (clk_out) highs++;
      p = clk_out;
    end
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int e, hi, p1, p2, n;
    void'($urandom(32'd77));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 reset state
    check(slow_sel == 1'b0, "R4", int'(slow_sel), 0);
    check(pll_off_req == 1'b0, "R4", int'(pll_off_req), 0);
    check_period(11, "R4");

    // R1 directed odd and even divisors
    load(2, 0, 0); wait_watch(30); check_period(2, "R1");
    load(1, 0, 0); wait_watch(30); check_period(1, "R1");
    load(4, 0, 0); wait_watch(30); check_period(4, "R1");
    // R3 clamp
    load(15, 0, 0); wait_watch(40); check_period(15, "R3");
    load(12, 0, 0); wait_watch(40); check_period(12, "R3");

    // R1/R3 random factors
    for (int i = 0; i < 12; i++) begin
      n = 1 + ($urandom % 15);
      load(n, 0, 0); wait_watch(40);
      check_period(n, (n > 11) ? "R3" : "R1");
    end

    // R5 factor change deferred to period end
    load(11, 0, 0); wait_watch(40);
    wait_rise();
    cfg_div = 4'd3; cfg_load = 1'b1;
    @(negedge clk); cfg_load = 1'b0;
    p1 = 2;
    while (clk_out) begin p1++; @(negedge clk); end
    while (!clk_out) begin p1++; @(negedge clk); end
    p1--;
    check(p1 == 12, "R5", p1, 12);
    p2 = 0;
    while (clk_out) begin p2++; @(negedge clk); end
    while (!clk_out) begin p2++; @(negedge clk); end
    check(p2 == 4, "R5", p2, 4);

    // R2 reference pass-through
    load(0, 0, 0); wait_watch(30);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1 check(clk_out == 1'b1, "R2", int'(clk_out), 1);
      @(negedge clk); #1 check(clk_out == 1'b0, "R2", int'(clk_out), 0);
    end

    // R6 slow clock, PLL off
    load(5, 0, 0); wait_watch(30);
    suspend_in = 1'b1; wait_watch(200);
    check(slow_sel == 1'b1, "R6", int'(slow_sel), 1);
    check(pll_off_req == 1'b1, "R6", int'(pll_off_req), 1);
    count_edges(300, e, hi);
    check(e > 2, "R6", e, 3);
    suspend_in = 1'b0; wait_watch(100);
    check(slow_sel == 1'b0, "R10", int'(slow_sel), 0);
    check(pll_off_req == 1'b0, "R10", int'(pll_off_req), 0);
    check_period(5, "R10");

    // R7 stop, PLL off
    load(6, 1, 0); wait_watch(30);
    suspend_in = 1'b1; wait_watch(100);
    count_edges(200, e, hi);
    check(hi == 0, "R7", hi, 0);
    check(pll_off_req == 1'b1, "R7", int'(pll_off_req), 1);
    check(slow_sel == 1'b0, "R7", int'(slow_sel), 0);
    suspend_in = 1'b0; wait_watch(100);
    check(pll_off_req == 1'b0, "R10", int'(pll_off_req), 0);
    check_period(6, "R10");

    // R8 slow clock, PLL kept on
    load(7, 0, 1); wait_watch(30);
    suspend_in = 1'b1; wait_watch(200);
    check(slow_sel == 1'b1, "R8", int'(slow_sel), 1);
    check(pll_off_req == 1'b0, "R8", int'(pll_off_req), 0);
    count_edges(300, e, hi);
    check(e > 2, "R8", e, 3);
    suspend_in = 1'b0; wait_watch(100);
    check(slow_sel == 1'b0, "R10", int'(slow_sel), 0);
    check_period(7, "R10");

    // R9 unaffected
    load(8, 1, 1); wait_watch(30);
    suspend_in = 1'b1; wait_watch(100);
    check(slow_sel == 1'b0, "R9", int'(slow_sel), 0);
    check(pll_off_req == 1'b0, "R9", int'(pll_off_req), 0);
    check_period(8, "R9");
    suspend_in = 1'b0; wait_watch(20);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule